// File: doc/BRIEF.md
# Mixed-Decay H-Bridge Current Chopper

This block controls the four switches of one H-bridge and regulates winding current by chopping. While enabled and not told to coast or brake, it drives the winding in the commanded direction. It keeps driving until a comparator on the shared current-sense stage reports that the current has reached its trip level. A fixed off period then follows. The off period always opens with fast decay, with every switch open so the body diodes return current against the supply. It then changes to slow decay, with both low-side switches closed so the current circulates through the low side. One all-off cycle follows, and then drive resumes. The trip input is ignored for a blanking window at the start of every drive phase, so that switching spikes cannot end drive early. Coast and brake commands hold a static bridge state without chopping. Dropping enable opens every switch at once.

The state machine has seven states. IDLE: all off while disabled. DRIVE: the latched direction is applied. FAST: all off, the first quarter of the off period. SLOW: both low sides on, the rest of the off period. DEAD: one all-off cycle wherever a leg changes its conducting switch. COAST: all off on command. BRAKE: both low sides on on command. The named transitions are as follows. Enable fall takes any state to IDLE. A trip outside blanking takes DRIVE to FAST. The end of the fast count takes FAST to SLOW. The end of the slow count takes SLOW to DEAD. DEAD goes to DRIVE, COAST or BRAKE. A direction change takes DRIVE to DEAD. Coast has priority over brake and is taken directly from any enabled state. Brake is taken directly from IDLE, FAST, SLOW, DEAD and COAST, and through DEAD from DRIVE. Release of brake goes to DEAD. Release of coast goes to DRIVE or BRAKE directly. IDLE goes to DRIVE, COAST or BRAKE.

Top module: `hbridge_chopper`

## Requirements
- R1: During and straight after reset all four switch outputs are 0, and the block is idle.
- R2: In DRIVE with the latched direction `dir_fwd`=1, the outputs are `hi1_on` and `lo2_on` only. With `dir_fwd`=0 they are `hi2_on` and `lo1_on` only. The output order used below is {hi1,lo1,hi2,lo2}: forward 1001, reverse 0110.
- R3: `trip_in` is ignored during the first BLANK_CYCLES cycles of each drive phase (default 3). A trip sampled on a later drive cycle ends drive at that edge.
- R4: After an accepted trip the outputs show FAST_LEN = max(1, OFF_CYCLES/4) cycles of 0000, then OFF_CYCLES−FAST_LEN cycles of 0101, then one 0000 cycle, then drive in the current direction. With the defaults (16) these are 4, 12 and 1 cycles.
- R5: Every off period begins with the fast phase. The slow phase is entered only from the fast phase.
- R6: A leg never has both its switches on. A switch never turns on in the cycle right after its leg partner was on.
- R7: A direction change during drive gives one 0000 cycle. Drive then restarts in the new direction with a fresh blanking window.
- R8: While `coast_req` is 1 (with enable), the outputs are 0000 and `trip_in` and `brake_req` have no effect. Coast overrides brake.
- R9: While `brake_req` is 1 (coast low, enabled), the outputs are 0101 and `trip_in` has no effect. From drive, brake is entered through one 0000 cycle.
- R10: When `drive_en` is 0 the outputs are 0000 in the same cycle, and the block is idle after the next edge. On re-enable, drive starts at the next edge with no dead cycle.
- R11: Release of coast starts drive at the next edge. Release of brake gives one 0000 cycle before drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_en | input | 1 | Enable; 0 forces all switches off |
| dir_fwd | input | 1 | 1 forward, 0 reverse |
| coast_req | input | 1 | Hold all switches off |
| brake_req | input | 1 | Hold both low-side switches on |
| trip_in | input | 1 | Current comparator trip, shared by both legs |
| hi1_on | output | 1 | High-side switch, leg 1 |
| lo1_on | output | 1 | Low-side switch, leg 1 |
| hi2_on | output | 1 | High-side switch, leg 2 |
| lo2_on | output | 1 | Low-side switch, leg 2 |

## Verification
The assertions check four things on every cycle. They check leg exclusivity and the one-cycle gap before a switch turns on in a leg. They check that only a trip ends drive into fast decay and that no trip ends it inside the blanking window. They also check that slow decay is entered only from fast decay, and that a low enable idles the machine. The exact lengths of the fast, slow and dead phases, the resume direction, and the immediate effect of a falling enable can be shown only by the bench scenarios. The same holds for the coast and brake priorities and their release paths. The bench shows them by comparing every cycle with a queue-based reference model under directed and pseudo-random stimulus.

// File: rtl/chopper_pkg.sv
`timescale 1ns/1ps
package chopper_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_FAST,
        ST_SLOW,
        ST_DEAD,
        ST_COAST,
        ST_BRAKE
    } chop_state_e;
endpackage

// File: rtl/chopper_phase_counter.sv
`timescale 1ns/1ps
module chopper_phase_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (restart)
            count <= '0;
        else if (count != CNT_TOP)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/chopper_fsm.sv
`timescale 1ns/1ps
module chopper_fsm
    import chopper_pkg::*;
#(
    parameter int OFF_CYCLES   = 16,
    parameter int BLANK_CYCLES = 3,
    parameter int CNT_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drive_en,
    input  logic             dir_fwd,
    input  logic             coast_req,
    input  logic             brake_req,
    input  logic             trip_in,
    input  logic [CNT_W-1:0] count,
    output chop_state_e      state,
    output logic             drive_dir,
    output logic             restart
);
    localparam int FAST_LEN = (OFF_CYCLES / 4 < 1) ? 1 : OFF_CYCLES / 4;
    localparam int SLOW_LEN = OFF_CYCLES - FAST_LEN;
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_LEN - 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_LEN - 1);
    localparam logic [CNT_W-1:0] BLANK_END = CNT_W'(BLANK_CYCLES);

    chop_state_e state_nx;

    always_comb begin
        state_nx = state;
        if (!drive_en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_COAST: begin
                    if (coast_req)      state_nx = ST_COAST;
                    else if (brake_req) state_nx = ST_BRAKE;
                    else                state_nx = ST_DRIVE;
                end
                ST_DRIVE: begin
                    if (coast_req)                          state_nx = ST_COAST;
                    else if (brake_req)                     state_nx = ST_DEAD;
                    else if (dir_fwd != drive_dir)          state_nx = ST_DEAD;
                    else if (trip_in && count >= BLANK_END) state_nx = ST_FAST;
                end
                ST_FAST: begin
                    if (coast_req)               state_nx = ST_COAST;
                    else if (brake_req)          state_nx = ST_BRAKE;
                    else if (count == FAST_LAST) state_nx = ST_SLOW;
                end
                ST_SLOW: begin
                    if (coast_req)               state_nx = ST_COAST;
                    else if (brake_req)          state_nx = ST_BRAKE;
                    else if (count == SLOW_LAST) state_nx = ST_DEAD;
                end
                ST_DEAD: begin
                    if (coast_req)      state_nx = ST_COAST;
                    else if (brake_req) state_nx = ST_BRAKE;
                    else                state_nx = ST_DRIVE;
                end
                ST_BRAKE: begin
                    if (coast_req)       state_nx = ST_COAST;
                    else if (!brake_req) state_nx = ST_DEAD;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    assign restart = (state_nx != state);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            drive_dir <= 1'b1;
        end else begin
            state <= state_nx;
            if (state_nx == ST_DRIVE && state != ST_DRIVE)
                drive_dir <= dir_fwd;
        end
    end

    // R10: a low enable always leaves the machine idle after the edge
    p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |=> state == ST_IDLE);

    // R3: no trip can end drive inside the blanking window
    p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRIVE && count < BLANK_END) |=> state != ST_FAST);

    // R4: drive ends in fast decay only because of a trip
    p_trip_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAST && $past(state) == ST_DRIVE) |-> $past(trip_in));

    // R5: slow decay is only reached from fast decay
    p_fast_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOW && $past(state) != ST_SLOW) |-> $past(state) == ST_FAST);
endmodule

// File: rtl/chopper_gate_decode.sv
`timescale 1ns/1ps
module chopper_gate_decode
    import chopper_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        drive_en,
    input  chop_state_e state,
    input  logic        drive_dir,
    output logic        hi1_on,
    output logic        lo1_on,
    output logic        hi2_on,
    output logic        lo2_on
);
    logic [3:0] gates;

    always_comb begin
        gates = 4'b0000;
        unique case (state)
            ST_DRIVE:             gates = drive_dir ? 4'b1001 : 4'b0110;
            ST_SLOW, ST_BRAKE:    gates = 4'b0101;
            ST_IDLE, ST_FAST,
            ST_DEAD, ST_COAST:    gates = 4'b0000;
            default:              gates = 4'b0000;
        endcase
        if (!drive_en)
            gates = 4'b0000;
    end

    assign {hi1_on, lo1_on, hi2_on, lo2_on} = gates;

    // R6: no leg ever conducts through both switches
    p_leg_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi1_on && lo1_on) && !(hi2_on && lo2_on));

    // R6: a switch never closes the cycle after its partner was closed
    p_dead_leg1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hi1_on) |-> !lo1_on) and ($past(lo1_on) |-> !hi1_on));
    p_dead_leg2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hi2_on) |-> !lo2_on) and ($past(lo2_on) |-> !hi2_on));
endmodule

// File: rtl/hbridge_chopper.sv
`timescale 1ns/1ps
module hbridge_chopper
    import chopper_pkg::*;
#(
    parameter int OFF_CYCLES   = 16,
    parameter int BLANK_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_en,
    input  logic dir_fwd,
    input  logic coast_req,
    input  logic brake_req,
    input  logic trip_in,
    output logic hi1_on,
    output logic lo1_on,
    output logic hi2_on,
    output logic lo2_on
);
    localparam int CNT_MAX = (OFF_CYCLES > BLANK_CYCLES) ? OFF_CYCLES : BLANK_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    chop_state_e      state;
    logic             drive_dir;
    logic             restart;
    logic [CNT_W-1:0] count;

    chopper_phase_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .count   (count)
    );

    chopper_fsm #(
        .OFF_CYCLES   (OFF_CYCLES),
        .BLANK_CYCLES (BLANK_CYCLES),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive_en  (drive_en),
        .dir_fwd   (dir_fwd),
        .coast_req (coast_req),
        .brake_req (brake_req),
        .trip_in   (trip_in),
        .count     (count),
        .state     (state),
        .drive_dir (drive_dir),
        .restart   (restart)
    );

    chopper_gate_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive_en  (drive_en),
        .state     (state),
        .drive_dir (drive_dir),
        .hi1_on    (hi1_on),
        .lo1_on    (lo1_on),
        .hi2_on    (hi2_on),
        .lo2_on    (lo2_on)
    );
endmodule

// File: tb/test_hbridge_chopper.sv
`timescale 1ns/1ps
module test_hbridge_chopper;
    localparam int N_OFF  = 16;
    localparam int N_BLK  = 3;
    localparam int F_LEN  = (N_OFF / 4 < 1) ? 1 : N_OFF / 4;
    localparam int S_LEN  = N_OFF - F_LEN;
    localparam int MD_IDLE = 0, MD_DRIVE = 1, MD_QUEUE = 2, MD_COAST = 3, MD_BRAKE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drive_en = 1'b0, dir_fwd = 1'b1, coast_req = 1'b0, brake_req = 1'b0, trip_in = 1'b0;
    logic hi1_on, lo1_on, hi2_on, lo2_on;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    hbridge_chopper #(.OFF_CYCLES(N_OFF), .BLANK_CYCLES(N_BLK)) i_hbridge_chopper (
        .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .dir_fwd(dir_fwd),
        .coast_req(coast_req), .brake_req(brake_req), .trip_in(trip_in),
        .hi1_on(hi1_on), .lo1_on(lo1_on), .hi2_on(hi2_on), .lo2_on(lo2_on)
    );

    wire [3:0] gv = {hi1_on, lo1_on, hi2_on, lo2_on};

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: gates=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: mode plus a queue of planned output vectors
    int         md = MD_IDLE;
    int         age = 0;
    logic       ddir = 1'b1;
    logic [3:0] plan[$];
    logic [3:0] prev_gv = 4'b0000;

    task automatic start_drive();
        md = MD_DRIVE; age = 0; ddir = dir_fwd;
    endtask

    task automatic queue_dead();
        plan.delete(); plan.push_back(4'b0000); md = MD_QUEUE;
    endtask

    always @(posedge clk) begin
        logic [3:0] ev;
        string      tag;
        #1;
        if (!rst_n) begin
            md = MD_IDLE; plan.delete(); prev_gv = 4'b0000;
        end else begin
            if (!drive_en) md = MD_IDLE;
            else if (md == MD_IDLE || md == MD_COAST) begin
                if (coast_req) md = MD_COAST;
                else if (brake_req) md = MD_BRAKE;
                else start_drive();
            end else if (md == MD_DRIVE) begin
                if (coast_req) md = MD_COAST;
                else if (brake_req || dir_fwd != ddir) queue_dead();
                else if (trip_in && age >= N_BLK) begin
                    plan.delete();
                    for (int i = 0; i < F_LEN; i++) plan.push_back(4'b0000);
                    for (int i = 0; i < S_LEN; i++) plan.push_back(4'b0101);
                    plan.push_back(4'b0000);
                    md = MD_QUEUE;
                end else age++;
            end else if (md == MD_QUEUE) begin
                if (coast_req) md = MD_COAST;
                else if (brake_req) md = MD_BRAKE;
                else if (plan.size() > 1) void'(plan.pop_front());
                else start_drive();
            end else begin
                if (coast_req) md = MD_COAST;
                else if (!brake_req) queue_dead();
            end

            case (md)
                MD_DRIVE: begin ev = ddir ? 4'b1001 : 4'b0110; tag = "R2"; end
                MD_QUEUE: begin ev = plan[0]; tag = "R4"; end
                MD_COAST: begin ev = 4'b0000; tag = "R8"; end
                MD_BRAKE: begin ev = 4'b0101; tag = "R9"; end
                default:  begin ev = 4'b0000; tag = "R10"; end
            endcase
            if (!drive_en) ev = 4'b0000;
            check(tag, gv, ev);

            // R6: leg exclusivity and one-cycle gap, checked at the ports
            n_checks++;
            if ((gv[3] && gv[2]) || (gv[1] && gv[0]) ||
                (prev_gv[3] && gv[2]) || (prev_gv[2] && gv[3]) ||
                (prev_gv[1] && gv[0]) || (prev_gv[0] && gv[1])) begin
                n_errors++;
                $display("FAIL R6: gates=%b after %b expected no overlap", gv, prev_gv);
            end
            prev_gv = gv;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] lfsr;
        cyc(3);
        check("R1", gv, 4'b0000);
        rst_n = 1'b1;
        cyc(1);
        check("R1", gv, 4'b0000);

        // R3: trip during the blanking window is ignored
        drive_en = 1'b1; dir_fwd = 1'b1; trip_in = 1'b1;
        cyc(3);
        trip_in = 1'b0;
        check("R3", gv, 4'b1001);
        cyc(4);
        check("R3", gv, 4'b1001);

        // R4/R5: off period shape and resume
        trip_in = 1'b1;
        cyc(1);
        trip_in = 1'b0;
        check("R5", gv, 4'b0000);
        cyc(F_LEN);
        check("R4", gv, 4'b0101);
        cyc(S_LEN);
        check("R4", gv, 4'b0000);
        cyc(1);
        check("R4", gv, 4'b1001);

        // R7: direction change mid drive
        cyc(5);
        dir_fwd = 1'b0;
        cyc(1);
        check("R7", gv, 4'b0000);
        cyc(1);
        check("R7", gv, 4'b0110);
        trip_in = 1'b1;
        cyc(2);
        check("R7", gv, 4'b0110);
        trip_in = 1'b0;
        cyc(3);

        // R9: brake from drive, trips ignored, then release (R11)
        brake_req = 1'b1;
        cyc(1);
        check("R9", gv, 4'b0000);
        cyc(1);
        check("R9", gv, 4'b0101);
        trip_in = 1'b1;
        cyc(3);
        trip_in = 1'b0;
        check("R9", gv, 4'b0101);
        brake_req = 1'b0;
        cyc(1);
        check("R11", gv, 4'b0000);
        cyc(1);
        check("R11", gv, 4'b0110);

        // R8: coast during an off period overrides brake, then release (R11)
        cyc(4);
        trip_in = 1'b1;
        cyc(1);
        trip_in = 1'b0;
        cyc(6);
        coast_req = 1'b1; brake_req = 1'b1; trip_in = 1'b1;
        cyc(1);
        check("R8", gv, 4'b0000);
        cyc(3);
        check("R8", gv, 4'b0000);
        brake_req = 1'b0; trip_in = 1'b0; coast_req = 1'b0;
        cyc(1);
        check("R11", gv, 4'b0110);

        // R10: enable drop opens all switches in the same cycle
        cyc(2);
        drive_en = 1'b0;
        #1;
        check("R10", gv, 4'b0000);
        cyc(2);
        drive_en = 1'b1;
        cyc(1);
        check("R10", gv, 4'b0110);

        // Pseudo-random traffic compared cycle by cycle with the model
        lfsr = 8'hA5;
        for (int k = 0; k < 2000; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            trip_in   = lfsr[0] & lfsr[2];
            if (lfsr == 8'h3C || lfsr == 8'h71) dir_fwd = ~dir_fwd;
            brake_req = (lfsr[7:4] == 4'hF);
            coast_req = (lfsr[7:3] == 5'h05);
            drive_en  = (lfsr != 8'h00 && lfsr != 8'h81);
            cyc(1);
        end
        finish_run();
    end
endmodule